// File: doc/BRIEF.md
# Paged Subroutine Call Unit

This unit carries out the short, page-relative subroutine call of a byte-oriented processor, along with the matching return. It holds a 16-bit program counter and an 8-bit stack pointer, and it owns a private 256-byte stack. A call takes a two-byte instruction. The opcode byte carries three target bits in its top positions and a fixed five-bit signature in its low positions. The operand byte carries the low eight target bits.

When a call is accepted, the unit first advances the program counter past the two-byte instruction. It then pushes that return address onto the stack, one byte per cycle, and replaces the low eleven bits of the counter with the target. The five page bits of the advanced counter are kept, so a call made from the last two bytes of a page lands in the following page.

A return pops two bytes and reloads the counter. Each strobe is sampled only while the unit is idle. A `done` pulse marks the final cycle of each operation.

Top module: `pgcall_unit`

## Requirements
- R1: After reset, `pc_q` is 0x0000, `sp_q` is 0x07, and `busy` and `done` are both low.
- R2: A call strobe is accepted only when `op_byte[4:0]` equals 5'b10001. Any other value leaves `pc_q` and `sp_q` unchanged and `busy` low.
- R3: After a call, `pc_q[10:0]` equals `{op_byte[7:5], arg_byte}`. `pc_q[15:11]` equals bits 15..11 of the pre-call PC plus 2.
- R4: A call raises `sp_q` by 2, modulo 256.
- R5: A call stores the return address (the pre-call PC plus 2) as follows: its low byte at the old SP plus 1, then its high byte at the old SP plus 2.
- R6: A return first reads the high byte at SP and decrements SP. It then reads the low byte at the new SP and decrements SP again. `pc_q` becomes {high, low}, and `sp_q` ends 2 lower, modulo 256.
- R7: After the edge that accepts a strobe, `busy` is high for three cycles. `done` is high only in the third of those cycles, for exactly one cycle.
- R8: Strobes that arrive while `busy` is high are ignored. If a valid call and a return are strobed together, the call is taken.
- R9: Nested calls unwind in last-in, first-out order, including when the stack pointer wraps past 255.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| call_go | input | 1 | Call strobe, sampled while idle |
| ret_go | input | 1 | Return strobe, sampled while idle |
| op_byte | input | 8 | First call byte: target bits 10..8 on top, signature below |
| arg_byte | input | 8 | Second call byte: target bits 7..0 |
| pc_q | output | 16 | Program counter |
| sp_q | output | 8 | Stack pointer |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume three things about the inputs: strobes come from logic in the same clock domain, op_byte and arg_byte are stable in the cycle a call is accepted, and a return is issued only after matching pushes have filled the stack bytes it reads.

The stimulus keeps to these assumptions. It drives every input on the falling edge and holds each strobe for exactly one cycle. It pairs every return with an earlier call. It crosses page and stack-pointer boundaries only through sequences of calls, so no byte is ever popped before it has been written.

// File: rtl/pgcall_pkg.sv
package pgcall_pkg;
  localparam int BYTE_W = 8;
  localparam int PC_W   = 2 * BYTE_W;
  localparam int PAGE_W = 11;
  localparam int SIG_W  = 5;
  localparam logic [SIG_W-1:0] CALL_SIG = 5'b10001;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_PUSH_LO = 3'd1,
    ST_PUSH_HI = 3'd2,
    ST_POP_HI  = 3'd3,
    ST_POP_LO  = 3'd4,
    ST_DONE    = 3'd5
  } pg_state_t;
endpackage

// File: rtl/pgcall_rstsync.sv
module pgcall_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/pgcall_stack.sv
module pgcall_stack #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_addr] <= wr_data;
  end

  assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/pgcall_ctrl.sv
module pgcall_ctrl
  import pgcall_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      acc_call,
  input  logic      acc_ret,
  output pg_state_t state,
  output logic      busy,
  output logic      done
);
  pg_state_t state_d;

  always_comb begin
    state_d = state;
    unique case (state)
      ST_IDLE: begin
        if (acc_call)     state_d = ST_PUSH_LO;
        else if (acc_ret) state_d = ST_POP_HI;
      end
      ST_PUSH_LO: state_d = ST_PUSH_HI;
      ST_PUSH_HI: state_d = ST_DONE;
      ST_POP_HI:  state_d = ST_POP_LO;
      ST_POP_LO:  state_d = ST_DONE;
      ST_DONE:    state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_d;
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_DONE);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> (busy && !done)); // R7
  AST_IDLE_PICK: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_call && acc_ret) |-> 1'b0); // R8
endmodule

// File: rtl/pgcall_unit.sv
module pgcall_unit
  import pgcall_pkg::*;
#(
  parameter int               SP_W     = 8,
  parameter logic [SP_W-1:0]  SP_INIT  = 8'h07,
  parameter logic [15:0]      PC_INIT  = 16'h0000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            call_go,
  input  logic            ret_go,
  input  logic [7:0]      op_byte,
  input  logic [7:0]      arg_byte,
  output logic [15:0]     pc_q,
  output logic [SP_W-1:0] sp_q,
  output logic            busy,
  output logic            done
);
  localparam int HI_TGT_W = PAGE_W - BYTE_W;
  localparam int KEEP_W   = PC_W - PAGE_W;

  logic              rst_int_n;
  pg_state_t         state;
  logic              acc_call, acc_ret;
  logic [PC_W-1:0]   pc_d;
  logic [SP_W-1:0]   sp_d;
  logic              pc_en, sp_en;
  logic [PAGE_W-1:0] tgt_q;
  logic [BYTE_W-1:0] hi_q;
  logic              wr_en;
  logic [SP_W-1:0]   wr_addr;
  logic [BYTE_W-1:0] wr_data, rd_data;

  pgcall_rstsync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(rst_int_n)
  );

  assign acc_call = !busy && call_go && (op_byte[SIG_W-1:0] == CALL_SIG);
  assign acc_ret  = !busy && ret_go && !acc_call;

  pgcall_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_int_n), .acc_call(acc_call), .acc_ret(acc_ret),
    .state(state), .busy(busy), .done(done)
  );

  // stack port: pushes go to SP+1, pops read at SP
  assign wr_en   = (state == ST_PUSH_LO) || (state == ST_PUSH_HI);
  assign wr_addr = sp_q + 1'b1;
  assign wr_data = (state == ST_PUSH_LO) ? pc_q[BYTE_W-1:0] : pc_q[PC_W-1:BYTE_W];

  pgcall_stack #(.ADDR_W(SP_W), .DATA_W(BYTE_W)) u_stack (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(sp_q), .rd_data(rd_data)
  );

  // next-state logic for PC and SP
  always_comb begin
    pc_d  = pc_q;
    pc_en = 1'b0;
    sp_d  = sp_q;
    sp_en = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (acc_call) begin
          pc_d  = pc_q + 16'd2;
          pc_en = 1'b1;
        end
      end
      ST_PUSH_LO: begin
        sp_d  = sp_q + 1'b1;
        sp_en = 1'b1;
      end
      ST_PUSH_HI: begin
        sp_d  = sp_q + 1'b1;
        sp_en = 1'b1;
        pc_d  = {pc_q[PC_W-1 -: KEEP_W], tgt_q};
        pc_en = 1'b1;
      end
      ST_POP_HI: begin
        sp_d  = sp_q - 1'b1;
        sp_en = 1'b1;
      end
      ST_POP_LO: begin
        sp_d  = sp_q - 1'b1;
        sp_en = 1'b1;
        pc_d  = {hi_q, rd_data};
        pc_en = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      pc_q <= PC_INIT;
      sp_q <= SP_INIT;
    end else begin
      if (pc_en) pc_q <= pc_d;
      if (sp_en) sp_q <= sp_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      tgt_q <= '0;
      hi_q  <= '0;
    end else begin
      if (acc_call)            tgt_q <= {op_byte[BYTE_W-1 -: HI_TGT_W], arg_byte};
      if (state == ST_POP_HI)  hi_q  <= rd_data;
    end
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!busy && !acc_call && !acc_ret) |=> ($stable(pc_q) && $stable(sp_q))); // R2
  AST_PAGE_KEEP: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state == ST_PUSH_HI) |=> (pc_q[PC_W-1 -: KEEP_W] == $past(pc_q[PC_W-1 -: KEEP_W]))); // R3
  AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state == ST_PUSH_LO || state == ST_PUSH_HI) |=> (sp_q == $past(sp_q) + 8'd1)); // R4
  AST_LO_FIRST: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state == ST_PUSH_LO) |=> (wr_data == $past(pc_q[PC_W-1:BYTE_W]))); // R5
  AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state == ST_POP_HI || state == ST_POP_LO) |=> (sp_q == $past(sp_q) - 8'd1)); // R6
  AST_RET_HIGH: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state == ST_POP_LO) |=> (pc_q[PC_W-1:BYTE_W] == $past(hi_q))); // R6
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (busy && !done) |=> busy); // R8
endmodule

// File: tb/pgcall_unit_test.sv
module pgcall_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        call_go, ret_go;
  logic [7:0]  op_byte, arg_byte;
  logic [15:0] pc_q;
  logic [7:0]  sp_q;
  logic        busy, done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference model state, built from the requirements
  logic [7:0]  m_stk [256];
  logic [15:0] m_pc;
  logic [7:0]  m_sp;

  always #5 clk = ~clk;

  pgcall_unit uut (
    .clk(clk), .rst_n(rst_n), .call_go(call_go), .ret_go(ret_go),
    .op_byte(op_byte), .arg_byte(arg_byte), .pc_q(pc_q), .sp_q(sp_q),
    .busy(busy), .done(done)
  );

  // vector: {kind[1:0], op[7:0], arg[7:0]}; kind 0 call, 1 return, 2 both strobes
  localparam int NV = 14;
  localparam logic [17:0] VEC [NV] = '{
    {2'd0, 8'hF1, 8'hFE}, {2'd0, 8'h11, 8'h10}, {2'd0, 8'h12, 8'h33},
    {2'd0, 8'h51, 8'h44}, {2'd1, 8'h00, 8'h00}, {2'd1, 8'h00, 8'h00},
    {2'd0, 8'hF1, 8'hFF}, {2'd0, 8'h31, 8'h00}, {2'd0, 8'hF0, 8'h01},
    {2'd2, 8'hB1, 8'h23}, {2'd1, 8'h00, 8'h00}, {2'd1, 8'h00, 8'h00},
    {2'd1, 8'h00, 8'h00}, {2'd1, 8'h00, 8'h00}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_op(input logic [1:0] kind, input logic [7:0] op,
                       input logic [7:0] arg, input bit poke);
    logic [15:0] r;
    logic [7:0]  hi, lo;
    bit callok, retok;
    @(negedge clk);
    call_go  = (kind != 2'd1);
    ret_go   = (kind != 2'd0);
    op_byte  = op;
    arg_byte = arg;
    callok = (kind != 2'd1) && (op[4:0] == 5'b10001);
    retok  = (kind != 2'd0) && !callok;
    if (callok) begin
      r = m_pc + 16'd2;
      m_sp = m_sp + 8'd1; m_stk[m_sp] = r[7:0];
      m_sp = m_sp + 8'd1; m_stk[m_sp] = r[15:8];
      m_pc = {r[15:11], op[7:5], arg};
    end else if (retok) begin
      hi = m_stk[m_sp]; m_sp = m_sp - 8'd1;
      lo = m_stk[m_sp]; m_sp = m_sp - 8'd1;
      m_pc = {hi, lo};
    end
    @(negedge clk);
    call_go = 1'b0;
    ret_go  = 1'b0;
    if (!callok && !retok) begin
      chk(!busy && pc_q == m_pc && sp_q == m_sp, "R2 ignored call",
          {7'd0, busy, pc_q, sp_q}, {8'd0, m_pc, m_sp});
      return;
    end
    chk(busy && !done, "R7 cycle1", {busy, done}, 2'b10);
    if (poke) begin
      call_go = 1'b1; ret_go = 1'b1; op_byte = 8'h11; arg_byte = 8'h99;
    end
    @(negedge clk);
    call_go = 1'b0; ret_go = 1'b0;
    chk(busy && !done, "R7 cycle2", {busy, done}, 2'b10);
    @(negedge clk);
    chk(busy && done, "R7 cycle3", {busy, done}, 2'b11);
    chk(pc_q == m_pc && sp_q == m_sp, callok ? "R3 R4 call result" : "R5 R6 return result",
        {pc_q, sp_q}, {m_pc, m_sp});
    @(negedge clk);
    chk(!busy && !done, "R7 end", {busy, done}, 2'b00);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; call_go = 1'b0; ret_go = 1'b0; op_byte = '0; arg_byte = '0;
    m_pc = 16'h0000; m_sp = 8'h07;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(pc_q == 16'h0000 && sp_q == 8'h07 && !busy && !done, "R1 reset",
        {6'd0, busy, done, pc_q, sp_q}, {8'd0, 16'h0000, 8'h07});

    // table walk: page crossing (R3), byte order (R5), bad opcode (R2), priority (R8)
    for (int i = 0; i < NV; i++) begin
      do_op(VEC[i][17:16], VEC[i][15:8], VEC[i][7:0], 1'b0);
    end

    // R8 strobes during busy have no effect on the result
    do_op(2'd0, 8'h71, 8'h5A, 1'b1);
    do_op(2'd1, 8'h00, 8'h00, 1'b1);

    // R9 deep nesting past SP 255 wrap, then unwind
    for (int i = 0; i < 130; i++) do_op(2'd0, 8'h91, 8'(i), 1'b0);
    chk(sp_q == 8'(8'h07 + 8'd4), "R4 R9 SP wrapped", {24'd0, sp_q}, {24'd0, 8'h0B});
    for (int i = 0; i < 130; i++) do_op(2'd1, 8'h00, 8'h00, 1'b0);
    chk(sp_q == 8'h07 && pc_q == m_pc, "R9 unwound", {pc_q, sp_q}, {m_pc, 8'h07});

    // R1 reset mid-operation returns to the reset state
    @(negedge clk); call_go = 1'b1; op_byte = 8'h11; arg_byte = 8'h01;
    @(negedge clk); call_go = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    chk(pc_q == 16'h0000 && sp_q == 8'h07 && !busy && !done, "R1 reset mid-op",
        {6'd0, busy, done, pc_q, sp_q}, {8'd0, 16'h0000, 8'h07});

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule